// File: doc/BRIEF.md
# T1 Error Counter Bank

This block keeps running tallies of four kinds of T1 line and framing error events: bipolar violations, CRC errors, framing bit errors and severely errored framing events. The two line-level tallies are wide counters and the two framing tallies are narrow counters. Three of them carry a sticky overflow flag. Software can zero any one counter, together with its flag, through a dedicated clear input.

A bipolar violation strobe is ignored while a qualifier input reports that it belongs to a legitimate zero-substitution pattern. A single level-sensitive group-two interrupt request is raised in two cases: an overflow flag of the bipolar, CRC or framing counter goes high, or the severely errored counter steps at all. The request stays up until it is acknowledged. Once per 125 us frame, a frame strobe copies every counter and flag into a snapshot set. A serial status inserter downstream reads that snapshot set.

Top module: `t1_err_counter_bank`

## Requirements
- R1: Each `bpv_evt` (when not masked) or `crc_evt` adds one to its 8-bit counter in the next cycle, and the counter wraps from 255 to 0.
- R2: Each `fe_evt` or `se_evt` adds one to its 4-bit counter in the next cycle, and the counter wraps from 15 to 0.
- R3: When the BPV, CRC or FE counter wraps to zero, its overflow flag is set in the same cycle. The flag then stays at 1 until that counter is cleared.
- R4: A high clear input for a counter makes that counter 0 and its flag 0 in the next cycle. An event on the same counter in the same cycle is discarded.
- R5: A `bpv_evt` with `b8zs_sub` high leaves the BPV counter and its flag unchanged.
- R6: `irq_g2` goes to 1 in the cycle in which any of the BPV, CRC or FE overflow flags goes from 0 to 1. A wrap while the flag is already 1 raises nothing.
- R7: Every counted `se_evt` sets `irq_g2` in the next cycle, including the step from 15 to 0.
- R8: `irq_g2` holds at 1 until `irq_ack` is sampled high, and then reads 0 in the next cycle. If a new raise condition occurs in the same cycle as the acknowledge, the request stays at 1.
- R9: When `frame_tick` is high, the snapshot outputs take the counter and flag values present in that cycle, and show them from the next cycle. At all other times the snapshot outputs hold.
- R10: While `rst_n` is low, every counter, flag, snapshot and `irq_g2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per 125 us frame |
| bpv_evt | input | 1 | Bipolar violation event strobe |
| b8zs_sub | input | 1 | Qualifier: current violation is part of a valid zero substitution |
| crc_evt | input | 1 | CRC error event strobe |
| fe_evt | input | 1 | Framing bit error event strobe |
| se_evt | input | 1 | Severely errored framing event strobe |
| clr_bpv | input | 1 | Clear BPV counter and flag |
| clr_crc | input | 1 | Clear CRC counter and flag |
| clr_fe | input | 1 | Clear FE counter and flag |
| clr_se | input | 1 | Clear SE counter |
| irq_ack | input | 1 | Interrupt acknowledge |
| bpv_cnt | output | WIDE_W | Live BPV count |
| bpv_ovf | output | 1 | BPV overflow flag |
| crc_cnt | output | WIDE_W | Live CRC count |
| crc_ovf | output | 1 | CRC overflow flag |
| fe_cnt | output | NARROW_W | Live framing error count |
| fe_ovf | output | 1 | FE overflow flag |
| se_cnt | output | NARROW_W | Live severely errored count |
| irq_g2 | output | 1 | Group-two interrupt request, level |
| snap_bpv_cnt | output | WIDE_W | Snapshot of BPV count |
| snap_bpv_ovf | output | 1 | Snapshot of BPV flag |
| snap_crc_cnt | output | WIDE_W | Snapshot of CRC count |
| snap_crc_ovf | output | 1 | Snapshot of CRC flag |
| snap_fe_cnt | output | NARROW_W | Snapshot of FE count |
| snap_fe_ovf | output | 1 | Snapshot of FE flag |
| snap_se_cnt | output | NARROW_W | Snapshot of SE count |

## Verification
The assertions check the following on every cycle:
- the single-step increment of the counters;
- that flags stay set;
- that a clear wins over a simultaneous event;
- the substitution mask;
- the interrupt raise and hold conditions;
- the frame-by-frame snapshot copy.

Some behaviour only the bench's scenarios can show. These are a full 256-event wrap that sets a flag exactly once, a second wrap that raises no request, and an acknowledge that collides with a new raise condition. The bench covers these with a behavioural reference model and with long directed and mixed event streams.

// File: rtl/t1_err_counter_bank.sv
module t1_err_counter_bank #(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                bpv_evt,
  input  logic                b8zs_sub,
  input  logic                crc_evt,
  input  logic                fe_evt,
  input  logic                se_evt,
  input  logic                clr_bpv,
  input  logic                clr_crc,
  input  logic                clr_fe,
  input  logic                clr_se,
  input  logic                irq_ack,
  output logic [WIDE_W-1:0]   bpv_cnt,
  output logic                bpv_ovf,
  output logic [WIDE_W-1:0]   crc_cnt,
  output logic                crc_ovf,
  output logic [NARROW_W-1:0] fe_cnt,
  output logic                fe_ovf,
  output logic [NARROW_W-1:0] se_cnt,
  output logic                irq_g2,
  output logic [WIDE_W-1:0]   snap_bpv_cnt,
  output logic                snap_bpv_ovf,
  output logic [WIDE_W-1:0]   snap_crc_cnt,
  output logic                snap_crc_ovf,
  output logic [NARROW_W-1:0] snap_fe_cnt,
  output logic                snap_fe_ovf,
  output logic [NARROW_W-1:0] snap_se_cnt
);

  localparam logic [WIDE_W-1:0]   WIDE_TOP   = '1;
  localparam logic [NARROW_W-1:0] NARROW_TOP = '1;

  // qualified increments: a clear always wins over an event
  wire bpv_hit = bpv_evt & ~b8zs_sub & ~clr_bpv;
  wire crc_hit = crc_evt & ~clr_crc;
  wire fe_hit  = fe_evt  & ~clr_fe;
  wire se_hit  = se_evt  & ~clr_se;

  wire bpv_wrap = bpv_hit & (bpv_cnt == WIDE_TOP);
  wire crc_wrap = crc_hit & (crc_cnt == WIDE_TOP);
  wire fe_wrap  = fe_hit  & (fe_cnt  == NARROW_TOP);

  wire irq_raise = (bpv_wrap & ~bpv_ovf) | (crc_wrap & ~crc_ovf)
                 | (fe_wrap & ~fe_ovf) | se_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_bpv) begin
      bpv_cnt <= '0;
      bpv_ovf <= 1'b0;
    end else if (bpv_hit) begin
      bpv_cnt <= bpv_cnt + 1'b1;
      if (bpv_wrap) bpv_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_crc) begin
      crc_cnt <= '0;
      crc_ovf <= 1'b0;
    end else if (crc_hit) begin
      crc_cnt <= crc_cnt + 1'b1;
      if (crc_wrap) crc_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_fe) begin
      fe_cnt <= '0;
      fe_ovf <= 1'b0;
    end else if (fe_hit) begin
      fe_cnt <= fe_cnt + 1'b1;
      if (fe_wrap) fe_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_se) se_cnt <= '0;
    else if (se_hit)      se_cnt <= se_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_g2 <= 1'b0;
    else if (irq_raise) irq_g2 <= 1'b1;
    else if (irq_ack)   irq_g2 <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_bpv_cnt <= '0;
      snap_bpv_ovf <= 1'b0;
      snap_crc_cnt <= '0;
      snap_crc_ovf <= 1'b0;
      snap_fe_cnt  <= '0;
      snap_fe_ovf  <= 1'b0;
      snap_se_cnt  <= '0;
    end else if (frame_tick) begin
      snap_bpv_cnt <= bpv_cnt;
      snap_bpv_ovf <= bpv_ovf;
      snap_crc_cnt <= crc_cnt;
      snap_crc_ovf <= crc_ovf;
      snap_fe_cnt  <= fe_cnt;
      snap_fe_ovf  <= fe_ovf;
      snap_se_cnt  <= se_cnt;
    end
  end

endmodule

// File: rtl/t1_err_counter_bank_chk.sv
module t1_err_counter_bank_chk #(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_tick,
  input logic                bpv_evt,
  input logic                b8zs_sub,
  input logic                crc_evt,
  input logic                se_evt,
  input logic                clr_bpv,
  input logic                clr_crc,
  input logic                clr_fe,
  input logic                clr_se,
  input logic                irq_ack,
  input logic [WIDE_W-1:0]   bpv_cnt,
  input logic                bpv_ovf,
  input logic [WIDE_W-1:0]   crc_cnt,
  input logic                crc_ovf,
  input logic                fe_ovf,
  input logic [NARROW_W-1:0] se_cnt,
  input logic                irq_g2,
  input logic [WIDE_W-1:0]   snap_crc_cnt,
  input logic [NARROW_W-1:0] snap_se_cnt
);

  assert_crc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_evt && !clr_crc) |=> crc_cnt == WIDE_W'($past(crc_cnt) + 1'b1));

  assert_se_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (se_evt && !clr_se) |=> se_cnt == NARROW_W'($past(se_cnt) + 1'b1));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_ovf && !clr_bpv) |=> bpv_ovf);

  assert_fe_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_ovf && !clr_fe) |=> fe_ovf);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_crc |=> (crc_cnt == '0 && !crc_ovf));

  assert_b8zs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_evt && b8zs_sub && !clr_bpv) |=> ($stable(bpv_cnt) && $stable(bpv_ovf)));

  assert_irq_on_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bpv_ovf) || $rose(crc_ovf) || $rose(fe_ovf)) |-> irq_g2);

  assert_irq_on_se_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (se_evt && !clr_se) |=> irq_g2);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_g2 && !irq_ack) |=> irq_g2);

  assert_snap_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (snap_crc_cnt == $past(crc_cnt) && snap_se_cnt == $past(se_cnt)));

  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(snap_crc_cnt) && $stable(snap_se_cnt)));

endmodule

bind t1_err_counter_bank t1_err_counter_bank_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bpv_evt(bpv_evt),
  .b8zs_sub(b8zs_sub), .crc_evt(crc_evt), .se_evt(se_evt), .clr_bpv(clr_bpv),
  .clr_crc(clr_crc), .clr_fe(clr_fe), .clr_se(clr_se), .irq_ack(irq_ack),
  .bpv_cnt(bpv_cnt), .bpv_ovf(bpv_ovf), .crc_cnt(crc_cnt), .crc_ovf(crc_ovf),
  .fe_ovf(fe_ovf), .se_cnt(se_cnt), .irq_g2(irq_g2),
  .snap_crc_cnt(snap_crc_cnt), .snap_se_cnt(snap_se_cnt)
);

// File: tb/t1_err_counter_bank_test.sv
module t1_err_counter_bank_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, frame_tick = 1'b0, bpv_evt = 1'b0, b8zs_sub = 1'b0;
  logic crc_evt = 1'b0, fe_evt = 1'b0, se_evt = 1'b0;
  logic clr_bpv = 1'b0, clr_crc = 1'b0, clr_fe = 1'b0, clr_se = 1'b0, irq_ack = 1'b0;
  logic [7:0] bpv_cnt, crc_cnt, snap_bpv_cnt, snap_crc_cnt;
  logic [3:0] fe_cnt, se_cnt, snap_fe_cnt, snap_se_cnt;
  logic bpv_ovf, crc_ovf, fe_ovf, irq_g2, snap_bpv_ovf, snap_crc_ovf, snap_fe_ovf;

  t1_err_counter_bank uut (.*);

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R10";

  // reference model state
  int m_b, m_c, m_f, m_s, m_irq, s_b, s_c, s_f, s_s;
  bit m_bo, m_co, m_fo, s_bo, s_co, s_fo;

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("bpv_cnt", bpv_cnt, m_b);  chk("bpv_ovf", bpv_ovf, m_bo);
    chk("crc_cnt", crc_cnt, m_c);  chk("crc_ovf", crc_ovf, m_co);
    chk("fe_cnt", fe_cnt, m_f);    chk("fe_ovf", fe_ovf, m_fo);
    chk("se_cnt", se_cnt, m_s);    chk("irq_g2", irq_g2, m_irq);
    chk("snap_bpv_cnt", snap_bpv_cnt, s_b); chk("snap_bpv_ovf", snap_bpv_ovf, s_bo);
    chk("snap_crc_cnt", snap_crc_cnt, s_c); chk("snap_crc_ovf", snap_crc_ovf, s_co);
    chk("snap_fe_cnt", snap_fe_cnt, s_f);   chk("snap_fe_ovf", snap_fe_ovf, s_fo);
    chk("snap_se_cnt", snap_se_cnt, s_s);
  endtask

  task automatic model_reset();
    m_b = 0; m_c = 0; m_f = 0; m_s = 0; m_irq = 0; m_bo = 0; m_co = 0; m_fo = 0;
    s_b = 0; s_c = 0; s_f = 0; s_s = 0; s_bo = 0; s_co = 0; s_fo = 0;
  endtask

  // advance model with the inputs applied this cycle, then clock and compare
  task automatic step();
    bit raise = 0;
    if (frame_tick) begin  // R9: copy pre-edge values
      s_b = m_b; s_bo = m_bo; s_c = m_c; s_co = m_co; s_f = m_f; s_fo = m_fo; s_s = m_s;
    end
    if (clr_bpv) begin m_b = 0; m_bo = 0; end
    else if (bpv_evt && !b8zs_sub) begin
      if (m_b == 255) begin if (!m_bo) raise = 1; m_bo = 1; end
      m_b = (m_b + 1) % 256;
    end
    if (clr_crc) begin m_c = 0; m_co = 0; end
    else if (crc_evt) begin
      if (m_c == 255) begin if (!m_co) raise = 1; m_co = 1; end
      m_c = (m_c + 1) % 256;
    end
    if (clr_fe) begin m_f = 0; m_fo = 0; end
    else if (fe_evt) begin
      if (m_f == 15) begin if (!m_fo) raise = 1; m_fo = 1; end
      m_f = (m_f + 1) % 16;
    end
    if (clr_se) m_s = 0;
    else if (se_evt) begin m_s = (m_s + 1) % 16; raise = 1; end
    if (raise) m_irq = 1;
    else if (irq_ack) m_irq = 0;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    {frame_tick, bpv_evt, b8zs_sub, crc_evt, fe_evt, se_evt} = '0;
    {clr_bpv, clr_crc, clr_fe, clr_se, irq_ack} = '0;
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R10"; compare();
    rst_n = 1'b1;

    tag = "R1";
    for (int i = 0; i < 40; i++) begin
      idle(); bpv_evt = i[0]; crc_evt = (i % 3) != 0; step();
    end

    tag = "R5";
    for (int i = 0; i < 40; i++) begin
      idle(); bpv_evt = 1; b8zs_sub = (i % 4) != 1; step();
    end

    tag = "R2";
    for (int i = 0; i < 40; i++) begin
      idle(); fe_evt = 1; se_evt = i[1]; step();
    end

    tag = "R8";
    idle(); irq_ack = 1; step();
    idle(); step(); step();

    tag = "R3";
    for (int i = 0; i < 300; i++) begin idle(); bpv_evt = 1; step(); end

    tag = "R6";
    idle(); irq_ack = 1; step();
    for (int i = 0; i < 260; i++) begin idle(); bpv_evt = 1; step(); end
    idle(); step();

    tag = "R4";
    idle(); clr_bpv = 1; bpv_evt = 1; clr_fe = 1; fe_evt = 1; step();
    idle(); clr_se = 1; se_evt = 1; crc_evt = 1; step();
    idle(); irq_ack = 1; step();

    tag = "R7";
    for (int i = 0; i < 20; i++) begin idle(); se_evt = 1; irq_ack = 1; step(); end
    idle(); irq_ack = 1; step();
    idle(); step();

    tag = "R9";
    for (int i = 0; i < 60; i++) begin
      idle(); frame_tick = (i % 7) == 3; crc_evt = 1; se_evt = i[0]; step();
    end

    tag = "R4 mix";
    for (int i = 0; i < 3000; i++) begin
      idle();
      bpv_evt = $urandom % 2; b8zs_sub = ($urandom % 4) == 0;
      crc_evt = $urandom % 2; fe_evt = $urandom % 2; se_evt = ($urandom % 8) == 0;
      clr_bpv = ($urandom % 97) == 0; clr_crc = ($urandom % 89) == 0;
      clr_fe = ($urandom % 53) == 0; clr_se = ($urandom % 61) == 0;
      irq_ack = ($urandom % 5) == 0; frame_tick = ($urandom % 16) == 0;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule